// File: doc/BRIEF.md
# Edge-Triggered Programmable Delay One-Shot

This block is a digital one-shot timer. A rising edge on one trigger input, or a falling edge on the other, starts an output pulse. The pulse lasts a programmed number of time-base ticks and then ends on its own. The pulse is presented as a complementary pair. The block runs on a single system clock. The time base arrives as a one-cycle tick enable, and the block counts those ticks only while a pulse is active.

A 4-bit code selects the pulse length. The length is always a power of two. The lower half of the code space selects short delays and the upper half selects very long ones. A mode input chooses what a trigger edge does during an active pulse: it either restarts the count, which stretches the pulse, or it is ignored. A second mode input chooses whether the external time base runs all the time or is enabled only while a pulse is in flight. The block reports that choice on a run-enable output. An active-high master reset ends a pulse at once and clears the count. An active-low power-on reset puts every register in its idle state.

Top module: `oneshot_delay_timer`

## Requirements
- R1: A rising edge on `trigRise` starts a pulse. The input is registered three times before it takes effect, so with the input changed before clock edge k, `pulseOut` is still low after edges k and k+1 and is high after edge k+2.
- R2: A falling edge on `trigFall` starts a pulse with the same three-edge latency as R1. When both trigger inputs carry one signal, its rising edge and its falling edge each start a pulse.
- R3: `pulseOutN` is always the inverse of `pulseOut`. When idle, `pulseOut` is 0 and `pulseOutN` is 1.
- R4: With `retrigEn` = 1, a trigger edge seen during a pulse restarts the tick count from zero. A retrigger detected D cycles after the first trigger, with one tick per cycle, gives a pulse D + L cycles long, where L is the selected length.
- R5: With `retrigEn` = 0, trigger edges seen during a pulse have no effect, and the pulse lasts exactly L ticks.
- R6: Let c be the value of `delaySel` read as an unsigned number. For c from 0 to 7, L = 2^(LOW_EXP+c) ticks. For c from 8 to 15, L = 2^(HIGH_EXP+c-8) ticks. Only ticks sampled while the pulse is high count, and a tick in the cycle that detects the trigger is not counted.
- R7: A pulse ends only at a clock edge that samples `tick` = 1. The edge that samples the L-th counted tick clears `pulseOut`.
- R8: `masterRst` = 1 clears `pulseOut` asynchronously and clears the count. Trigger edges seen while it is high are ignored. A trigger after release starts a full-length pulse.
- R9: While `rstN` = 0 the block is idle: `pulseOut` = 0 and `pulseOutN` = 1, with the trigger inputs held at their idle levels (`trigRise` low, `trigFall` high).
- R10: `timeBaseEn` is 1 whenever `oscRun` = 1. When `oscRun` = 0, `timeBaseEn` is 1 exactly while a pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| masterRst | input | 1 | Asynchronous pulse abort and count clear, active high |
| trigRise | input | 1 | Trigger input that responds to its rising edge |
| trigFall | input | 1 | Trigger input that responds to its falling edge |
| retrigEn | input | 1 | 1: a trigger during a pulse restarts the count; 0: such a trigger is ignored |
| delaySel | input | 4 | Pulse length code |
| oscRun | input | 1 | 1: time base runs all the time; 0: time base runs only during a pulse |
| tick | input | 1 | Time-base tick, one clock wide |
| pulseOut | output | 1 | Pulse output, high while active |
| pulseOutN | output | 1 | Complement of `pulseOut` |
| timeBaseEn | output | 1 | Run enable for the external time base |

## Verification
The bench builds the block with LOW_EXP = 1 and HIGH_EXP = 5. This keeps the longest pulse at 4096 ticks, so all sixteen select codes can be swept in full. Each code is run twice: once with a tick every cycle and once with a tick every third cycle. Across those runs the triggers cycle through the rising input, the falling input and the tied pair. The smaller upper exponent changes only the size of the count. The decoding and the split of the code space between the two halves are the same as at the default, so the split and the 2^(HIGH_EXP) boundary are both checked at a measurable length. Separate runs cover retrigger extension against lockout, and an abort in the middle of a pulse with a trigger pulse arriving during the abort.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Strobes from the pulse control to the tick counter.
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } cntStrobe_t;
endpackage

// File: rtl/oneshot_trig_sync.sv
module oneshot_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic masterRst,
  input  logic trigRise,
  input  logic trigFall,
  output logic trigEdge
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  // Each pipe holds the synchroniser stages plus one history stage.
  logic [PIPE_W-1:0] risePipe;
  logic [PIPE_W-1:0] fallPipe;

  // The pipes come out of reset at the idle levels of their inputs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      risePipe <= '0;
      fallPipe <= '1;
    end else begin
      risePipe <= {risePipe[PIPE_W-2:0], trigRise};
      fallPipe <= {fallPipe[PIPE_W-2:0], trigFall};
    end
  end

  logic riseSeen;
  logic fallSeen;
  assign riseSeen = risePipe[SYNC_STAGES-1] & ~risePipe[SYNC_STAGES];
  assign fallSeen = ~fallPipe[SYNC_STAGES-1] & fallPipe[SYNC_STAGES];

  // No edge is reported while the master reset is held.
  assign trigEdge = ~masterRst & (riseSeen | fallSeen);
endmodule

// File: rtl/oneshot_count_path.sv
module oneshot_count_path
  import oneshot_pkg::*;
#(
  parameter int LOW_EXP  = 1,
  parameter int HIGH_EXP = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterRst,
  input  cntStrobe_t cntStb,
  input  logic [3:0] delaySel,
  output logic       lastTick
);
  localparam int CNT_W = HIGH_EXP + 7;
  localparam int EXP_W = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] termVal;
  logic [EXP_W-1:0] selExp;
  logic [EXP_W-1:0] shAmt;

  // The terminal count is 2^selExp - 1, formed as a right-shifted mask of ones.
  always_comb begin
    if (delaySel[3]) selExp = EXP_W'(HIGH_EXP) + EXP_W'(delaySel[2:0]);
    else             selExp = EXP_W'(LOW_EXP) + EXP_W'(delaySel[2:0]);
    shAmt   = EXP_W'(CNT_W) - selExp;
    termVal = {CNT_W{1'b1}} >> shAmt;
  end

  assign lastTick = (cnt == termVal);

  always_ff @(posedge clk or negedge rstN or posedge masterRst) begin
    if (!rstN)                cnt <= '0;
    else if (masterRst)       cnt <= '0;
    else if (cntStb.cntClear) cnt <= '0;
    else if (cntStb.cntInc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterRst,
  input  logic       trigEdge,
  input  logic       retrigEn,
  input  logic       tick,
  input  logic       lastTick,
  output cntStrobe_t cntStb,
  output logic       active
);
  logic endHit;

  always_comb begin
    // A trigger starts a pulse when idle, and restarts one only in retrigger mode.
    cntStb.cntClear = trigEdge & (~active | retrigEn);
    cntStb.cntInc   = active & tick & ~lastTick & ~cntStb.cntClear;
    endHit          = active & tick & lastTick & ~cntStb.cntClear;
  end

  always_ff @(posedge clk or negedge rstN or posedge masterRst) begin
    if (!rstN)                active <= 1'b0;
    else if (masterRst)       active <= 1'b0;
    else if (cntStb.cntClear) active <= 1'b1;
    else if (endHit)          active <= 1'b0;
  end
endmodule

// File: rtl/oneshot_delay_timer.sv
module oneshot_delay_timer
  import oneshot_pkg::*;
#(
  parameter int LOW_EXP     = 1,
  parameter int HIGH_EXP    = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterRst,
  input  logic       trigRise,
  input  logic       trigFall,
  input  logic       retrigEn,
  input  logic [3:0] delaySel,
  input  logic       oscRun,
  input  logic       tick,
  output logic       pulseOut,
  output logic       pulseOutN,
  output logic       timeBaseEn
);
  logic       trigEdge;
  logic       lastTick;
  logic       active;
  cntStrobe_t cntStb;

  oneshot_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .masterRst(masterRst),
    .trigRise(trigRise), .trigFall(trigFall), .trigEdge(trigEdge)
  );

  oneshot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .masterRst(masterRst), .trigEdge(trigEdge),
    .retrigEn(retrigEn), .tick(tick), .lastTick(lastTick),
    .cntStb(cntStb), .active(active)
  );

  oneshot_count_path #(.LOW_EXP(LOW_EXP), .HIGH_EXP(HIGH_EXP)) u_dp (
    .clk(clk), .rstN(rstN), .masterRst(masterRst), .cntStb(cntStb),
    .delaySel(delaySel), .lastTick(lastTick)
  );

  assign pulseOut   = active;
  assign pulseOutN  = ~active;
  assign timeBaseEn = oscRun | active;
endmodule

// File: rtl/oneshot_delay_timer_chk.sv
module oneshot_delay_timer_chk
  import oneshot_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       masterRst,
  input logic       retrigEn,
  input logic       oscRun,
  input logic       tick,
  input logic       pulseOut,
  input logic       timeBaseEn,
  input logic       trigEdge,
  input logic       lastTick,
  input cntStrobe_t cntStb
);
  p_start_needs_edge_r1: assert property (@(posedge clk) disable iff (!rstN || masterRst)
    $rose(pulseOut) |-> $past(trigEdge));

  p_idle_edge_starts_r2: assert property (@(posedge clk) disable iff (!rstN || masterRst)
    (trigEdge && !pulseOut) |=> pulseOut);

  p_retrig_keeps_high_r4: assert property (@(posedge clk) disable iff (!rstN || masterRst)
    (trigEdge && retrigEn) |=> pulseOut);

  p_lockout_no_clear_r5: assert property (@(posedge clk) disable iff (!rstN || masterRst)
    (trigEdge && pulseOut && !retrigEn) |-> !cntStb.cntClear);

  p_no_early_end_r6: assert property (@(posedge clk) disable iff (!rstN || masterRst)
    (pulseOut && !lastTick) |=> pulseOut);

  p_end_on_tick_r7: assert property (@(posedge clk) disable iff (!rstN || masterRst)
    (pulseOut && !tick) |=> pulseOut);

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    masterRst |-> !pulseOut);

  p_timebase_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    !timeBaseEn |-> (!pulseOut && !oscRun));
endmodule

bind oneshot_delay_timer oneshot_delay_timer_chk u_chk (.*);

// File: tb/oneshot_delay_timer_tb.sv
module oneshot_delay_timer_tb;
  localparam int LOW_EXP  = 1;
  localparam int HIGH_EXP = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterRst = 1'b0;
  logic       trigRise = 1'b0;
  logic       trigFall = 1'b1;
  logic       retrigEn = 1'b0;
  logic [3:0] delaySel = 4'd0;
  logic       oscRun = 1'b0;
  logic       tick = 1'b0;
  logic       pulseOut;
  logic       pulseOutN;
  logic       timeBaseEn;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  oneshot_delay_timer #(.LOW_EXP(LOW_EXP), .HIGH_EXP(HIGH_EXP)) u_dut (
    .clk(clk), .rstN(rstN), .masterRst(masterRst), .trigRise(trigRise),
    .trigFall(trigFall), .retrigEn(retrigEn), .delaySel(delaySel),
    .oscRun(oscRun), .tick(tick), .pulseOut(pulseOut),
    .pulseOutN(pulseOutN), .timeBaseEn(timeBaseEn)
  );

  task automatic chkEq(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lenOf(input int code);
    if (code < 8) return longint'(1) << (LOW_EXP + code);
    return longint'(1) << (HIGH_EXP + code - 8);
  endfunction

  // kind 0: pulse on trigRise; 1: pulse on trigFall; 2: tied pair rises; 3: tied pair falls
  task automatic startPulse(input int kind);
    string req;
    req = (kind == 1 || kind == 3) ? "R2 start" : "R1 start";
    @(negedge clk);
    tick = 1'b0;
    case (kind)
      0: trigRise = 1'b1;
      1: trigFall = 1'b0;
      2: begin trigRise = 1'b1; trigFall = 1'b1; end
      default: begin trigRise = 1'b0; trigFall = 1'b0; end
    endcase
    @(negedge clk);
    if (kind == 0) trigRise = 1'b0;
    if (kind == 1) trigFall = 1'b1;
    chkEq({req, " low after first edge"}, pulseOut, 0);
    @(negedge clk);
    chkEq({req, " low after second edge"}, pulseOut, 0);
    @(negedge clk);
    chkEq({req, " high after third edge"}, pulseOut, 1);
  endtask

  task automatic measure(input int period, input longint expLen);
    int phase = 0;
    int guard = 0;
    longint ticks = 0;
    bit lastT = 1'b0;
    bit compOk = 1'b1;
    bit tbOk = 1'b1;
    forever begin
      bit t;
      t = (phase == 0);
      phase = (phase + 1) % period;
      tick = t;
      lastT = t;
      if (t) ticks++;
      @(negedge clk);
      guard++;
      if (pulseOutN == pulseOut) compOk = 1'b0;
      if (!pulseOut) break;
      if (!timeBaseEn) tbOk = 1'b0;
      if (guard > 60000) break;
    end
    tick = 1'b0;
    chkEq("R6 pulse length in ticks", ticks, expLen);
    chkEq("R7 end on a tick", lastT, 1);
    chkEq("R3 complementary outputs", compOk, 1);
    chkEq("R10 time base enabled in pulse", tbOk, 1);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    chkEq("R3 idle pulseOut", pulseOut, 0);
    chkEq("R3 idle pulseOutN", pulseOutN, 1);
    chkEq("R10 idle time base enable", timeBaseEn, oscRun);
  endtask

  // Second trigger on trigRise dly cycles after the first; tick every cycle.
  task automatic retrigRun(input bit mode, input int dly, input longint expCycles, input string req);
    longint highCnt = 0;
    retrigEn = mode;
    tick = 1'b1;
    @(negedge clk);
    trigRise = 1'b1;
    for (int cyc = 1; cyc < 5000; cyc++) begin
      @(negedge clk);
      if (cyc == 1 || cyc == dly + 1) trigRise = 1'b0;
      if (cyc == dly) trigRise = 1'b1;
      if (pulseOut) highCnt++;
      else if (highCnt > 0) break;
    end
    tick = 1'b0;
    chkEq(req, highCnt, expCycles);
    retrigEn = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // R9: power-on reset state
    repeat (3) @(negedge clk);
    chkEq("R9 reset pulseOut", pulseOut, 0);
    chkEq("R9 reset pulseOutN", pulseOutN, 1);
    chkEq("R10 reset time base enable", timeBaseEn, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chkEq("R9 idle after release", pulseOut, 0);

    // R1 R2 R6 R7: full sweep of codes, two tick rates, all trigger forms
    for (int p = 1; p <= 3; p += 2) begin
      oscRun = (p == 3);
      for (int c = 0; c < 16; c++) begin
        delaySel = 4'(c);
        if (c % 3 == 2) begin
          startPulse(2);
          measure(p, lenOf(c));
          idleCheck();
          startPulse(3);
          measure(p, lenOf(c));
          @(negedge clk);
          trigFall = 1'b1;
          trigRise = 1'b0;
        end else begin
          startPulse(c % 3);
          measure(p, lenOf(c));
        end
        idleCheck();
      end
    end

    // R4 / R5: retrigger against lockout, length 8, second trigger 5 cycles later
    oscRun = 1'b0;
    delaySel = 4'd2;
    retrigRun(1'b1, 5, 5 + 8, "R4 retrigger extends pulse");
    idleCheck();
    retrigRun(1'b0, 5, 8, "R5 lockout ignores trigger");
    idleCheck();
    retrigRun(1'b1, 30, 8, "R4 trigger after end starts new pulse");
    idleCheck();

    // R8: abort in the middle of a pulse, trigger during abort, resume afterwards
    delaySel = 4'd7;
    startPulse(0);
    tick = 1'b1;
    repeat (20) @(negedge clk);
    masterRst = 1'b1;
    #1;
    chkEq("R8 async abort", pulseOut, 0);
    @(negedge clk);
    trigRise = 1'b1;
    @(negedge clk);
    trigRise = 1'b0;
    repeat (4) @(negedge clk);
    masterRst = 1'b0;
    begin
      bit stayLow = 1'b1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (pulseOut) stayLow = 1'b0;
      end
      chkEq("R8 trigger during abort ignored", stayLow, 1);
    end
    tick = 1'b0;
    startPulse(0);
    measure(1, lenOf(7));
    idleCheck();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule